// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns three reset causes into one internal active-low reset for the rest of the chip. The causes are an asynchronous external active-low reset pin, a synchronous power-on detect pulse, and a synchronous supply-good flag. Power-on events preload an 8-bit idle countdown with all ones. The internal reset stays asserted until that countdown underflows, so it is held for 256 clock periods. After the first underflow, later power-on pulses are ignored until the supply drops. The supply-good flag also serves as the block's own synchronous active-low reset. When it falls, the internal reset asserts in the same cycle and the countdown is rearmed.

The external pin passes through a two-stage synchronizer. It takes effect only when it stays low for a full instruction cycle, given as a parameter in clocks. A qualified pin assertion resets the chip in exactly the same way as the power-on path. It also raises a one-cycle wake request that takes the core out of halt. The watchdog and clock-monitor arming outputs stay low, meaning inhibited, for as long as the chip is in reset. Both come out armed at the moment of release, when the downstream logic also presets its service-window and monitor bits.

Top module: `rstseq_top`

## Requirements
- R1: While `supply_ok` is 0, `rst_n_int`, `wd_arm`, `cm_arm` and `halt_exit` are all 0. A fall of `supply_ok` drives `rst_n_int` to 0 in the same cycle.
- R2: After `supply_ok` rises, `rst_n_int` stays 0 for exactly 256 clock edges that sample `supply_ok` high, and goes to 1 after the 256th edge.
- R3: A `por_pulse` sampled while the countdown is still running reloads it with 0xFF. `rst_n_int` then goes to 1 only after the 256th edge following the pulse.
- R4: Once the countdown has underflowed, `por_pulse` has no effect on `rst_n_int` for as long as `supply_ok` stays 1.
- R5: A low on `ext_rst_n` that lasts fewer than `CYC_CLKS` consecutive synchronized samples has no effect on any output.
- R6: A low on `ext_rst_n` lasting at least `CYC_CLKS` samples drives `rst_n_int` to 0 after edge `CYC_CLKS`+1, counted from the first edge that samples the low. The release takes effect after the second edge that samples the pin high.
- R7: `halt_exit` is a single-cycle pulse in the cycle in which an external reset qualifies. It fires even when `rst_n_int` is already 0 for another reason.
- R8: `wd_arm` and `cm_arm` are 0 in every cycle in which `rst_n_int` is 0, and 1 in every cycle in which it is 1.
- R9: `rst_n_int` is 1 only when the countdown has finished, the external reset is not qualified, and `supply_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| supply_ok | input | 1 | Synchronous supply-good flag; also the block's active-low reset |
| por_pulse | input | 1 | Synchronous power-on detect pulse |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| rst_n_int | output | 1 | Internal reset to the chip, active low |
| halt_exit | output | 1 | One-cycle wake request out of halt |
| wd_arm | output | 1 | Watchdog armed (0 = inhibited, 1 = armed with maximum window) |
| cm_arm | output | 1 | Clock monitor armed (0 = inhibited, 1 = armed with its bit set) |

## Verification
Two functions can land in the same cycle: the idle countdown reaching underflow, and the external pin qualifying. The bench raises `supply_ok` and then pulls the pin low six edges before the countdown ends. Both events then fall on the same edge. The scoreboard expects `rst_n_int` to stay 0 across the underflow and `halt_exit` to pulse in that cycle. It then expects release only after the pin's own release latency.

// File: rtl/rstseq_pkg.sv
// Package: shared constants for the reset sequencer.
// Assumes: nothing; holds only widths used by more than one module.
package rstseq_pkg;
    localparam int IDLE_W = 8;   // width of the idle countdown
endpackage

// File: rtl/rstseq_pin_filter.sv
// Module: rstseq_pin_filter
// Synchronizes the asynchronous reset pin and qualifies it. The pin counts
// as asserted only after CYC_CLKS consecutive low samples. Raises a
// one-cycle halt-exit request when qualification is reached.
// Assumes: supply_ok is already synchronous and acts as the active-low reset.
module rstseq_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CYC_CLKS    = 4
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic ext_rst_n,
    output logic pin_low,
    output logic halt_exit
);
    localparam int LW = $clog2(CYC_CLKS + 1);
    localparam logic [LW-1:0] QUAL = LW'(CYC_CLKS);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [LW-1:0]          low_cnt;
    logic                   pin_low_d;
    logic                   synced_n;

    assign synced_n = sync_q[SYNC_STAGES-1];

    // Synchronizer chain for the pin; its idle value is high.
    always_ff @(posedge clk) begin
        if (!supply_ok) sync_q <= '1;
        else            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_rst_n};
    end

    // Counts consecutive low samples, saturating at the qualify count.
    always_ff @(posedge clk) begin
        if (!supply_ok)         low_cnt <= '0;
        else if (synced_n)      low_cnt <= '0;
        else if (low_cnt != QUAL) low_cnt <= low_cnt + 1'b1;
    end

    // Remembers the previous qualified state for edge detection.
    always_ff @(posedge clk) begin
        if (!supply_ok) pin_low_d <= 1'b0;
        else            pin_low_d <= pin_low;
    end

    assign pin_low   = (low_cnt == QUAL);
    assign halt_exit = pin_low & ~pin_low_d;

    // R5: qualification can only begin while the synchronized pin was low
    p_short_filter_r5: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(pin_low) |-> $past(!synced_n));

    // R7: halt request never lasts more than one cycle
    p_halt_pulse_r7: assert property (@(posedge clk) disable iff (!supply_ok)
        halt_exit |=> !halt_exit);
endmodule

// File: rtl/rstseq_idle_ctr.sv
// Module: rstseq_idle_ctr
// Idle countdown for the power-on path. It is preloaded with all ones on
// power-on and counts down once per clock. When it underflows, busy
// clears and por_done is latched. Power-on pulses are ignored after that,
// until supply_ok falls.
// Assumes: supply_ok low is the synchronous reset and rearms the countdown.
module rstseq_idle_ctr #(
    parameter int CW = rstseq_pkg::IDLE_W
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic por_pulse,
    output logic busy,
    output logic por_done
);
    logic [CW-1:0] cnt;
    logic          reload;

    assign reload = por_pulse & ~por_done;

    // Countdown: preload on power-on, decrement while busy, stop on underflow.
    always_ff @(posedge clk) begin
        if (!supply_ok) begin
            cnt      <= '1;
            busy     <= 1'b1;
            por_done <= 1'b0;
        end else if (reload) begin
            cnt  <= '1;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                busy     <= 1'b0;
                por_done <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R3: a pulse accepted before completion leaves a full, running count
    p_reload_r3: assert property (@(posedge clk) disable iff (!supply_ok)
        (por_pulse && !por_done) |=> (busy && cnt == '1));

    // R4: once underflow happened, it stays recorded while supply is good
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!supply_ok)
        por_done |=> (por_done && !busy));
endmodule

// File: rtl/rstseq_top.sv
// Module: rstseq_top
// Merges the supply-good flag, the qualified external pin and the power-on
// countdown into one internal active-low reset. It also drives the halt
// wake request and the watchdog / clock-monitor arming levels.
// Assumes: supply_ok and por_pulse are synchronous to clk; ext_rst_n is not.
module rstseq_top #(
    parameter int SYNC_STAGES = 2,
    parameter int CYC_CLKS    = 4,
    parameter int IDLE_W      = rstseq_pkg::IDLE_W
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic por_pulse,
    input  logic ext_rst_n,
    output logic rst_n_int,
    output logic halt_exit,
    output logic wd_arm,
    output logic cm_arm
);
    logic pin_low;
    logic busy;
    logic por_done;

    rstseq_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .CYC_CLKS    (CYC_CLKS)
    ) pin_i (
        .clk       (clk),
        .supply_ok (supply_ok),
        .ext_rst_n (ext_rst_n),
        .pin_low   (pin_low),
        .halt_exit (halt_exit)
    );

    rstseq_idle_ctr #(
        .CW (IDLE_W)
    ) idle_i (
        .clk       (clk),
        .supply_ok (supply_ok),
        .por_pulse (por_pulse),
        .busy      (busy),
        .por_done  (por_done)
    );

    // Internal reset: any cause holds it; a supply drop acts in the same cycle.
    always_comb begin
        rst_n_int = supply_ok & ~busy & ~pin_low;
    end

    // Arming: inhibited throughout reset, armed with preset bits on release.
    always_comb begin
        wd_arm = rst_n_int;
        cm_arm = rst_n_int;
    end

    // R8: watchdog and clock monitor are never armed inside reset
    p_arm_inhibit_r8: assert property (@(posedge clk) disable iff (!supply_ok)
        !rst_n_int |-> (!wd_arm && !cm_arm));

    // R9: release only with countdown finished and pin not qualified
    p_release_r9: assert property (@(posedge clk) disable iff (!supply_ok)
        rst_n_int |-> (por_done && !pin_low));
endmodule

// File: tb/rstseq_top_tb_top.sv
// Bench: scoreboard. Stimulus code pushes expected output items tagged
// with the cycle count; a monitor pops and compares them at falling edges.
module rstseq_top_tb_top;
    localparam int CYC = 4;

    typedef struct {
        int   cyc;
        logic rst;
        logic halt;
        logic arm;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic por_pulse = 1'b0;
    logic ext_rst_n = 1'b1;
    logic rst_n_int, halt_exit, wd_arm, cm_arm;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    rstseq_top #(.SYNC_STAGES(2), .CYC_CLKS(CYC), .IDLE_W(8)) dut_i (
        .clk       (clk),
        .supply_ok (supply_ok),
        .por_pulse (por_pulse),
        .ext_rst_n (ext_rst_n),
        .rst_n_int (rst_n_int),
        .halt_exit (halt_exit),
        .wd_arm    (wd_arm),
        .cm_arm    (cm_arm)
    );

    task automatic expect_at(input int c, input logic r, input logic h,
                             input logic a, input string req);
        exp_t e;
        e.cyc = c; e.rst = r; e.halt = h; e.arm = a; e.req = req;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare all expectations due in the current cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (rst_n_int !== e.rst || halt_exit !== e.halt ||
                wd_arm !== e.arm || cm_arm !== e.arm) begin
                n_bad++;
                $display("FAIL %s cyc=%0d actual rst=%b halt=%b wd=%b cm=%b expected rst=%b halt=%b arm=%b",
                         e.req, cyc, rst_n_int, halt_exit, wd_arm, cm_arm,
                         e.rst, e.halt, e.arm);
            end
        end
    end

    initial begin
        int base;
        // R1: reset state while supply is low
        expect_at(2, 0, 0, 0, "R1");
        expect_at(3, 0, 0, 0, "R1");
        step(4);

        // R2/R3: supply rises, then a pulse at +100 restarts the countdown
        base = cyc;
        expect_at(base + 1,   0, 0, 0, "R2");
        expect_at(base + 356, 0, 0, 0, "R3");
        expect_at(base + 357, 1, 0, 1, "R3");
        expect_at(base + 357, 1, 0, 1, "R8");
        supply_ok = 1'b1;
        step(100);
        por_pulse = 1'b1;
        step(1);
        por_pulse = 1'b0;
        step(259);

        // R4: pulse after underflow is ignored
        base = cyc;
        expect_at(base + 1, 1, 0, 1, "R4");
        expect_at(base + 3, 1, 0, 1, "R4");
        por_pulse = 1'b1;
        step(1);
        por_pulse = 1'b0;
        step(5);

        // R5: glitch of CYC-1 samples is filtered
        base = cyc;
        expect_at(base + 4, 1, 0, 1, "R5");
        expect_at(base + 7, 1, 0, 1, "R5");
        ext_rst_n = 1'b0;
        step(CYC - 1);
        ext_rst_n = 1'b1;
        step(8);

        // R6/R7: qualified pin reset, halt pulse, release latency
        base = cyc;
        expect_at(base + 5, 1, 0, 1, "R6");
        expect_at(base + 6, 0, 1, 0, "R7");
        expect_at(base + 7, 0, 0, 0, "R7");
        ext_rst_n = 1'b0;
        step(10);
        base = cyc;
        expect_at(base + 2, 0, 0, 0, "R6");
        expect_at(base + 3, 1, 0, 1, "R6");
        ext_rst_n = 1'b1;
        step(5);

        // R1: supply drop asserts reset in the same cycle
        base = cyc;
        expect_at(base, 0, 0, 0, "R1");
        supply_ok = 1'b0;
        step(3);

        // R2/R9/R7: new countdown; pin qualifies on the underflow edge
        base = cyc;
        expect_at(base + 255, 0, 0, 0, "R2");
        expect_at(base + 256, 0, 1, 0, "R9");
        expect_at(base + 257, 0, 0, 0, "R9");
        expect_at(base + 262, 0, 0, 0, "R9");
        expect_at(base + 263, 1, 0, 1, "R9");
        supply_ok = 1'b1;
        step(250);
        ext_rst_n = 1'b0;
        step(10);
        ext_rst_n = 1'b1;
        step(6);

        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, cyc=%0d expected < 5000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule